// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Wrapping Converter

This block turns a 64-bit IEEE-754 double into a 32-bit two's-complement integer the way script-language integer coercion does. The fraction is always discarded toward zero, whatever rounding mode the rest of the chip uses. A magnitude too large for 32 signed bits is not clamped. The result is the low 32 bits of the truncated integer, with the sign applied, and read as a signed number.

An operand presented with `in_valid` is converted in one registered stage. The converted value, a four-bit condition nibble, and per-conversion invalid and inexact flags appear one cycle later together with `out_valid`. Two sticky flags collect the exception flags of every conversion since reset. The Z bit of the nibble tells software whether the conversion was exact and in range. The other three bits of the nibble are always zero.

Top module: `dbl_to_i32_wrap`

## Requirements
- R1: A conversion accepted with `in_valid` high shows `out_valid` high on the next cycle. When `in_valid` is low, `out_valid` falls on the next cycle, and the result, nibble and per-conversion flags keep their last values.
- R2: A finite in-range operand gives its value truncated toward zero, in two's complement (1.5 gives 1, -1.5 gives 0xFFFFFFFF).
- R3: A finite operand whose truncated integer lies outside [-2^31, 2^31-1] gives that integer, with its sign applied, modulo 2^32. When the unbiased exponent is 84 or more, the low 32 bits are all zero and the result is 0.
- R4: An operand whose exponent field is all ones (NaN or infinity) gives result 0, invalid 1, inexact 0 and Z 0.
- R5: A zero of either sign gives 0 with Z 1 and no exception. A subnormal gives 0 with inexact 1 and Z 0.
- R6: Z is 1 exactly when the operand is finite, loses no fraction bits and lies in the signed 32-bit range.
- R7: `out_nzcv` is {N, Z, C, V}, with bit 3 as N and bit 0 as V. N, C and V are always 0.
- R8: A finite operand asserts inexact when fraction bits are lost or it is out of range. Out of range also asserts invalid.
- R9: The sticky invalid and inexact outputs are the OR of the per-conversion flags of every conversion since reset. They never fall before reset.
- R10: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is presented this cycle |
| in_operand | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result of the previous cycle's operand |
| out_result | output | 32 | Wrapped signed integer |
| out_nzcv | output | 4 | Condition nibble {N, Z, C, V} |
| out_invalid | output | 1 | Invalid flag of this conversion |
| out_inexact | output | 1 | Inexact flag of this conversion |
| out_sticky_invalid | output | 1 | Accumulated invalid since reset |
| out_sticky_inexact | output | 1 | Accumulated inexact since reset |

## Verification
On every cycle, the assertions check the one-cycle valid latency and the holding of outputs on idle cycles. They also check that the N, C and V bits stay zero, that Z never appears together with an exception flag, that NaN and infinity give a zero result with invalid set, that zero operands give an exact zero, and that the sticky flags never fall. The wrapped arithmetic itself can only be shown by the directed scenarios. These include the exact edges of the signed range, values a little past them, large exponents near the shift limit, fractions with negative signs and subnormals, and a sequence that makes the sticky flags build up.

// File: rtl/dj_conv_pkg.sv
package dj_conv_pkg;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int FP_W      = 1 + EXP_W + FRAC_W;
    localparam int INT_W     = 32;
    localparam int MANT_W    = FRAC_W + 1;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    // largest shift that can still leave a set bit in the low INT_W integer bits
    localparam int SHIFT_MAX = FRAC_W + INT_W - 1;
    localparam int WIDE_W    = MANT_W + SHIFT_MAX;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);
    localparam int NIB_W     = 4;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_SPEC
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_fields_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             exact;
        logic             invalid;
        logic             inexact;
    } conv_out_t;

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
        logic [NIB_W-1:0] nzcv;
        logic             invalid;
        logic             inexact;
        logic             stk_invalid;
        logic             stk_inexact;
    } conv_state_t;
endpackage

// File: rtl/dj_fp_unpack.sv
module dj_fp_unpack
    import dj_conv_pkg::*;
(
    input  logic [FP_W-1:0]   operand,
    output fp_fields_t        fields,
    output fp_class_e         cls,
    output logic [MANT_W-1:0] mant
);
    assign fields = fp_fields_t'(operand);
    assign mant   = {(fields.expo != '0), fields.frac};

    always_comb begin
        if (fields.expo == '1) begin
            cls = CLS_SPEC;
        end else if (fields.expo == '0) begin
            cls = (fields.frac == '0) ? CLS_ZERO : CLS_SUBN;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/dj_int_shift.sv
module dj_int_shift
    import dj_conv_pkg::*;
(
    input  logic              sign,
    input  logic [EXP_W-1:0]  expo,
    input  logic [MANT_W-1:0] mant,
    output logic [INT_W-1:0]  mag_low,
    output logic              frac_lost,
    output logic              out_of_range
);
    localparam logic [EXP_W-1:0] BIAS_E  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] SHMAX_E = EXP_W'(SHIFT_MAX);
    localparam int UPPER_W = WIDE_W - FRAC_W - INT_W;

    logic              below_one;
    logic              too_big;
    logic [EXP_W-1:0]  unbiased;
    logic [SH_W-1:0]   shamt;
    logic [WIDE_W-1:0] wide;
    logic [UPPER_W-1:0] upper;
    logic              top_bit;
    logic [INT_W-2:0]  rest;
    logic              fits;

    assign below_one = (expo < BIAS_E);
    assign unbiased  = expo - BIAS_E;
    assign too_big   = !below_one && (unbiased > SHMAX_E);
    assign shamt     = (below_one || too_big) ? '0 : SH_W'(unbiased);

    // fixed point: FRAC_W fraction bits below the integer part
    assign wide    = {{SHIFT_MAX{1'b0}}, mant} << shamt;
    assign upper   = wide[WIDE_W-1 -: UPPER_W];
    assign top_bit = wide[FRAC_W + INT_W - 1];
    assign rest    = wide[FRAC_W +: (INT_W - 1)];
    // magnitude 2^(INT_W-1) is representable only when negative
    assign fits    = (upper == '0) && (!top_bit || (sign && rest == '0));

    always_comb begin
        if (below_one) begin
            mag_low      = '0;
            frac_lost    = (mant != '0);
            out_of_range = 1'b0;
        end else if (too_big) begin
            mag_low      = '0;
            frac_lost    = 1'b0;
            out_of_range = 1'b1;
        end else begin
            mag_low      = wide[FRAC_W +: INT_W];
            frac_lost    = |wide[FRAC_W-1:0];
            out_of_range = !fits;
        end
    end
endmodule

// File: rtl/dj_flag_gen.sv
module dj_flag_gen
    import dj_conv_pkg::*;
(
    input  fp_class_e        cls,
    input  logic             sign,
    input  logic [INT_W-1:0] mag_low,
    input  logic             frac_lost,
    input  logic             out_of_range,
    output conv_out_t        res
);
    always_comb begin
        if (cls == CLS_SPEC) begin
            res.value   = '0;
            res.exact   = 1'b0;
            res.invalid = 1'b1;
            res.inexact = 1'b0;
        end else begin
            res.value   = sign ? (~mag_low + INT_W'(1)) : mag_low;
            res.exact   = !frac_lost && !out_of_range;
            res.invalid = out_of_range;
            res.inexact = frac_lost || out_of_range;
        end
    end
endmodule

// File: rtl/dbl_to_i32_wrap.sv
module dbl_to_i32_wrap
    import dj_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic [NIB_W-1:0] out_nzcv,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_sticky_invalid,
    output logic             out_sticky_inexact
);
    fp_fields_t        fields;
    fp_class_e         cls;
    logic [MANT_W-1:0] mant;
    logic [INT_W-1:0]  mag_low;
    logic              frac_lost;
    logic              oor;
    conv_out_t         conv;
    conv_state_t       state_d, state_q;

    dj_fp_unpack i_unpack (
        .operand (in_operand),
        .fields  (fields),
        .cls     (cls),
        .mant    (mant)
    );

    dj_int_shift i_shift (
        .sign         (fields.sign),
        .expo         (fields.expo),
        .mant         (mant),
        .mag_low      (mag_low),
        .frac_lost    (frac_lost),
        .out_of_range (oor)
    );

    dj_flag_gen i_flags (
        .cls          (cls),
        .sign         (fields.sign),
        .mag_low      (mag_low),
        .frac_lost    (frac_lost),
        .out_of_range (oor),
        .res          (conv)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.result      = conv.value;
            state_d.nzcv        = {1'b0, conv.exact, 2'b00};
            state_d.invalid     = conv.invalid;
            state_d.inexact     = conv.inexact;
            state_d.stk_invalid = state_q.stk_invalid | conv.invalid;
            state_d.stk_inexact = state_q.stk_inexact | conv.inexact;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid          = state_q.valid;
    assign out_result         = state_q.result;
    assign out_nzcv           = state_q.nzcv;
    assign out_invalid        = state_q.invalid;
    assign out_inexact        = state_q.inexact;
    assign out_sticky_invalid = state_q.stk_invalid;
    assign out_sticky_inexact = state_q.stk_inexact;
endmodule

// File: rtl/dbl_to_i32_wrap_chk.sv
module dbl_to_i32_wrap_chk
    import dj_conv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [FP_W-1:0]  in_operand,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic [NIB_W-1:0] out_nzcv,
    input logic             out_invalid,
    input logic             out_inexact,
    input logic             out_sticky_invalid,
    input logic             out_sticky_inexact
);
    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_nzcv)
                       && $stable(out_invalid) && $stable(out_inexact)));
    p_special_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand[FP_W-2 -: EXP_W] == '1)
        |=> (out_result == '0 && out_invalid && !out_inexact && !out_nzcv[2]));
    p_zero_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand[FP_W-2:0] == '0)
        |=> (out_result == '0 && out_nzcv[2] && !out_invalid && !out_inexact));
    p_z_no_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nzcv[2]) |-> (!out_invalid && !out_inexact));
    p_ncv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_nzcv[3] == 1'b0 && out_nzcv[1:0] == 2'b00));
    p_invalid_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid && !out_inexact) |-> (out_result == '0));
    p_sticky_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sticky_invalid |=> out_sticky_invalid);
    p_sticky_inx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sticky_inexact |=> out_sticky_inexact);
    p_sticky_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> out_sticky_invalid);
endmodule

bind dbl_to_i32_wrap dbl_to_i32_wrap_chk i_chk (.*);

// File: tb/test_dbl_to_i32_wrap.sv
module test_dbl_to_i32_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_nzcv;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_sticky_invalid;
    logic        out_sticky_inexact;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dbl_to_i32_wrap i_dbl_to_i32_wrap (
        .clk                (clk),
        .rst_n              (rst_n),
        .in_valid           (in_valid),
        .in_operand         (in_operand),
        .out_valid          (out_valid),
        .out_result         (out_result),
        .out_nzcv           (out_nzcv),
        .out_invalid        (out_invalid),
        .out_inexact        (out_inexact),
        .out_sticky_invalid (out_sticky_invalid),
        .out_sticky_inexact (out_sticky_inexact)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // one conversion; sampled on the falling edge after the capturing edge
    task automatic convert(input string tag, input logic [63:0] op, input logic [31:0] exp_res,
                           input logic exp_z, input logic exp_inv, input logic exp_inx);
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        @(negedge clk);
        in_valid   = 1'b0;
        check({tag, " R1 valid"}, 64'(out_valid), 64'd1);
        check({tag, " result"}, 64'(out_result), 64'(exp_res));
        check({tag, " R7 nzcv"}, 64'(out_nzcv), 64'({1'b0, exp_z, 2'b00}));
        check({tag, " invalid"}, 64'(out_invalid), 64'(exp_inv));
        check({tag, " inexact"}, 64'(out_inexact), 64'(exp_inx));
    endtask

    task automatic t_reset_r10();
        check("R10 valid", 64'(out_valid), 64'd0);
        check("R10 result", 64'(out_result), 64'd0);
        check("R10 nzcv", 64'(out_nzcv), 64'd0);
        check("R10 sticky", 64'({out_sticky_invalid, out_sticky_inexact}), 64'd0);
    endtask

    task automatic t_truncate_r2();
        convert("R2 42", $realtobits(42.0), 32'd42, 1'b1, 1'b0, 1'b0);
        convert("R2 1.5", $realtobits(1.5), 32'd1, 1'b0, 1'b0, 1'b1);
        convert("R2 -1.5", $realtobits(-1.5), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
        convert("R2 0.75", $realtobits(0.75), 32'd0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_range_edges_r6();
        convert("R6 max", $realtobits(2147483647.0), 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        convert("R6 min", $realtobits(-2147483648.0), 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        convert("R6 min-frac", $realtobits(-2147483648.5), 32'h8000_0000, 1'b0, 1'b0, 1'b1);
        convert("R8 2^31", $realtobits(2147483648.0), 32'h8000_0000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_wrap_r3();
        convert("R3 2^32+5", $realtobits(4294967301.0), 32'd5, 1'b0, 1'b1, 1'b1);
        convert("R3 -(2^32+5)", $realtobits(-4294967301.0), 32'hFFFF_FFFB, 1'b0, 1'b1, 1'b1);
        convert("R3 1e10", $realtobits(1.0e10), 32'h540B_E400, 1'b0, 1'b1, 1'b1);
        convert("R3 3e9", $realtobits(3.0e9), 32'hB2D0_5E00, 1'b0, 1'b1, 1'b1);
        convert("R3 2^83+2^31", 64'h4520_0000_0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b1);
        convert("R3 2^84+2^32", 64'h4530_0000_0000_0001, 32'd0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_special_r4();
        convert("R4 +inf", 64'h7FF0_0000_0000_0000, 32'd0, 1'b0, 1'b1, 1'b0);
        convert("R4 -inf", 64'hFFF0_0000_0000_0000, 32'd0, 1'b0, 1'b1, 1'b0);
        convert("R4 nan", 64'h7FF8_0000_0000_0001, 32'd0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_zero_sub_r5();
        convert("R5 +0", 64'h0000_0000_0000_0000, 32'd0, 1'b1, 1'b0, 1'b0);
        convert("R5 -0", 64'h8000_0000_0000_0000, 32'd0, 1'b1, 1'b0, 1'b0);
        convert("R5 subn", 64'h8000_0000_0000_0001, 32'd0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_hold_r1();
        convert("R1 seed", $realtobits(-7.0), 32'hFFFF_FFF9, 1'b1, 1'b0, 1'b0);
        in_operand = $realtobits(99.5);
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        check("R1 idle result", 64'(out_result), 64'hFFFF_FFF9);
        check("R1 idle nzcv", 64'(out_nzcv), 64'h4);
    endtask

    task automatic t_sticky_r9();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        convert("R9 exact", $realtobits(5.0), 32'd5, 1'b1, 1'b0, 1'b0);
        check("R9 none", 64'({out_sticky_invalid, out_sticky_inexact}), 64'd0);
        convert("R9 frac", $realtobits(2.25), 32'd2, 1'b0, 1'b0, 1'b1);
        check("R9 inexact only", 64'({out_sticky_invalid, out_sticky_inexact}), 64'd1);
        convert("R9 nan", 64'h7FF8_0000_0000_0000, 32'd0, 1'b0, 1'b1, 1'b0);
        check("R9 both", 64'({out_sticky_invalid, out_sticky_inexact}), 64'd3);
        convert("R9 exact again", $realtobits(8.0), 32'd8, 1'b1, 1'b0, 1'b0);
        check("R9 kept", 64'({out_sticky_invalid, out_sticky_inexact}), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r10();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r10();
        t_truncate_r2();
        t_range_edges_r6();
        t_wrap_r3();
        t_special_r4();
        t_zero_sub_r5();
        t_hold_r1();
        t_sticky_r9();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule